// File: doc/BRIEF.md
# Scratchpad Memory with Atomic Bit and Increment Operations

This block is a small on-chip word store that threads use for semaphores, mailboxes and shared counters. A requester issues one command at a time on a valid/ready command port: a burst read, a burst write, a masked bit update (plain or test variant) or an in-place increment. The word address is the sum of two operands carried with the command, and a burst walks consecutive words from there. Write data arrives on its own valid/ready stream. Every command produces one or more beats on a valid/ready response port. Each beat carries the requester tag, an error flag and a last flag. A read beat also carries the word read, and a test operation's beat carries the word's value from before the update.

All accesses go through a single-port memory with one cycle of read latency, controlled by one sequencer. A read-modify-write reads the word in one cycle and writes the new value in the next cycle, so no other access can come between them. Command handshake rule: `cmd_ready` is high only while the sequencer is idle. A new command is therefore taken only after the previous command's last response beat has been accepted, which keeps responses in command order. Write-data rule: `wd_ready` is high only while a write burst is collecting its beats. Response rule: a beat stays on the port, with every field unchanged, until `rsp_ready` is seen high at a clock edge.

Top module: `spad_atomic`

## Requirements
- R1: The store holds 1024 words of 32 bits. The word address is `cmd_base + cmd_ofs`, and a word written at an address reads back unchanged from the same address.
- R2: If `cmd_base + cmd_ofs` exceeds 1023, the command leaves memory unchanged and returns one beat with `rsp_err`=1, `rsp_last`=1 and `rsp_data`=0. A write burst in this case still consumes and discards its data beats.
- R3: `cmd_len` = n moves n+1 words (1 to 8) at consecutive addresses. A read returns n+1 beats in address order, and `rsp_last` is set only on the final beat.
- R4: A burst that runs past word 1023 continues at word 0.
- R5: Opcode 2 (set) makes the word `word | cmd_mask`, and opcode 3 (clear) makes it `word & ~cmd_mask`. Both return one beat with `rsp_data`=0.
- R6: Opcode 4 (test and set) and opcode 5 (test and clear) update the word as in R5 and return the word's value from before the update in `rsp_data`.
- R7: Opcode 6 (increment) adds 1 to the word modulo 2^32. It consumes no write data and returns one beat with `rsp_data`=0.
- R8: Every read-modify-write does its memory read and its write-back at the same address in consecutive cycles, with no other access in between.
- R9: After reset, `cmd_ready`=1 and `rsp_valid`=0. Each command ends with exactly one beat that has `rsp_last`=1, and `rsp_id` echoes that command's `cmd_id`. Opcodes 0 (read) and 1 (write) are the burst commands. A write returns a single done beat once its last data beat is taken.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, all response fields hold steady. No command is accepted while a response is pending.
- R11: The reserved opcode 7 is reported as an error, as in R2, and changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_op | input | 3 | Opcode (0 rd, 1 wr, 2 set, 3 clr, 4 tset, 5 tclr, 6 incr, 7 reserved) |
| cmd_base | input | 10 | First address operand |
| cmd_ofs | input | 10 | Second address operand |
| cmd_len | input | 3 | Burst length minus one |
| cmd_mask | input | 32 | Bit mask for bit operations |
| cmd_id | input | 4 | Requester tag |
| wd_valid | input | 1 | Write data beat offered |
| wd_ready | output | 1 | Write data beat taken |
| wd_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the beat |
| rsp_data | output | 32 | Read data or value before the update |
| rsp_id | output | 4 | Echoed requester tag |
| rsp_last | output | 1 | Final beat of the command |
| rsp_err | output | 1 | Address out of range or reserved opcode |

## Verification
A wrong burst pointer or remaining-count register shows up at the ports within one burst. The read data comes back from the wrong word, or `rsp_last` is set on the wrong beat or never set, so the next command is never accepted. A fault in the update logic is caught by the response of the test operation itself or by the next read of that word, a few cycles later. A wrong error latch shows up in one of two ways: a word that should be untouched reads back changed, or a valid access comes back flagged as an error.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_SET  = 3'd2,
    OP_CLR  = 3'd3,
    OP_TSET = 3'd4,
    OP_TCLR = 3'd5,
    OP_INC  = 3'd6,
    OP_RSV  = 3'd7
  } spad_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RDQ, S_WR, S_MR, S_MW, S_RSP
  } spad_st_e;
endpackage

// File: rtl/spad_ram.sv
module spad_ram #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spad_addr.sv
module spad_addr #(
  parameter int AW   = 10,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [AW-1:0]   opa,
  input  logic [AW-1:0]   opb,
  input  logic [LENW-1:0] len,
  output logic            range_err,
  output logic [AW-1:0]   ptr,
  output logic            last_beat
);
  logic [AW:0]     sum;
  logic [LENW-1:0] rem;

  assign sum       = {1'b0, opa} + {1'b0, opb};
  assign range_err = sum[AW];
  assign last_beat = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      rem <= '0;
    end else if (load) begin
      ptr <= sum[AW-1:0];
      rem <= len;
    end else if (step) begin
      ptr <= ptr + 1'b1;
      rem <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/spad_rmw_alu.sv
module spad_rmw_alu
  import spad_pkg::*;
#(
  parameter int DW = 32
) (
  input  spad_op_e      op,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] new_word,
  output logic [DW-1:0] ret_word
);
  always_comb begin
    unique case (op)
      OP_SET, OP_TSET: new_word = old_word | mask;
      OP_CLR, OP_TCLR: new_word = old_word & ~mask;
      OP_INC:          new_word = old_word + 1'b1;
      default:         new_word = old_word;
    endcase
    ret_word = (op == OP_TSET || op == OP_TCLR) ? old_word : '0;
  end
endmodule

// File: rtl/spad_atomic.sv
module spad_atomic
  import spad_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 10,
  parameter int LENW = 3,
  parameter int IDW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_base,
  input  logic [AW-1:0]   cmd_ofs,
  input  logic [LENW-1:0] cmd_len,
  input  logic [DW-1:0]   cmd_mask,
  input  logic [IDW-1:0]  cmd_id,
  input  logic            wd_valid,
  output logic            wd_ready,
  input  logic [DW-1:0]   wd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic [IDW-1:0]  rsp_id,
  output logic            rsp_last,
  output logic            rsp_err
);
  spad_st_e       st, st_n;
  spad_op_e       op_q;
  logic [DW-1:0]  mask_q;
  logic           err_q;
  logic           accept, range_err, last_beat, step;
  logic [AW-1:0]  ptr;
  logic           mem_we;
  logic [DW-1:0]  mem_wdata, mem_rdata, alu_new, alu_ret;
  logic           cmd_bad;

  assign cmd_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_WR);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_bad   = range_err || (spad_op_e'(cmd_op) == OP_RSV);
  assign step      = (st == S_RDQ) || (st == S_WR && wd_valid);

  spad_addr #(.AW(AW), .LENW(LENW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .opa(cmd_base), .opb(cmd_ofs), .len(cmd_len),
    .range_err(range_err), .ptr(ptr), .last_beat(last_beat)
  );

  spad_rmw_alu #(.DW(DW)) u_alu (
    .op(op_q), .old_word(mem_rdata), .mask(mask_q),
    .new_word(alu_new), .ret_word(alu_ret)
  );

  spad_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = wd_data;
    if (st == S_WR && wd_valid && !err_q) mem_we = 1'b1;
    if (st == S_MW) begin
      mem_we    = 1'b1;
      mem_wdata = alu_new;
    end
  end

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE: if (accept) begin
        if (spad_op_e'(cmd_op) == OP_WR) st_n = S_WR;
        else if (cmd_bad)                st_n = S_RSP;
        else if (spad_op_e'(cmd_op) == OP_RD) st_n = S_RD;
        else                             st_n = S_MR;
      end
      S_RD:  st_n = S_RDQ;
      S_RDQ: st_n = S_RSP;
      S_WR:  if (wd_valid && last_beat) st_n = S_RSP;
      S_MR:  st_n = S_MW;
      S_MW:  st_n = S_RSP;
      S_RSP: if (rsp_ready) st_n = rsp_last ? S_IDLE : S_RD;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_RD;
      mask_q    <= '0;
      err_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_id    <= '0;
      rsp_last  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        op_q   <= spad_op_e'(cmd_op);
        mask_q <= cmd_mask;
        err_q  <= cmd_bad;
        rsp_id <= cmd_id;
        if (cmd_bad && spad_op_e'(cmd_op) != OP_WR) begin
          rsp_valid <= 1'b1;
          rsp_data  <= '0;
          rsp_last  <= 1'b1;
          rsp_err   <= 1'b1;
        end
      end
      if (st == S_RDQ) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rdata;
        rsp_last  <= last_beat;
        rsp_err   <= 1'b0;
      end
      if (st == S_WR && wd_valid && last_beat) begin
        rsp_valid <= 1'b1;
        rsp_data  <= '0;
        rsp_last  <= 1'b1;
        rsp_err   <= err_q;
      end
      if (st == S_MW) begin
        rsp_valid <= 1'b1;
        rsp_data  <= alu_ret;
        rsp_last  <= 1'b1;
        rsp_err   <= 1'b0;
      end
      if (st == S_RSP && rsp_ready) rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spad_atomic_chk.sv
module spad_atomic_chk #(
  parameter int DW  = 32,
  parameter int AW  = 10,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_ready,
  input logic           wd_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DW-1:0]  rsp_data,
  input logic [IDW-1:0] rsp_id,
  input logic           rsp_last,
  input logic           rsp_err,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           rmw_rd_phase,
  input logic           rmw_wr_phase,
  input logic           err_q
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_id)
      && $stable(rsp_last) && $stable(rsp_err)); // R10
  AST_NO_CMD_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R10
  AST_RMW_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_rd_phase |=> mem_we && $stable(mem_addr)); // R8
  AST_RMW_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_wr_phase |-> $past(rmw_rd_phase)); // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !cmd_ready |-> !mem_we); // R2
  AST_ERR_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_last && rsp_data == '0); // R2
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, wd_ready, rsp_valid})); // R9
endmodule

bind spad_atomic spad_atomic_chk #(.DW(DW), .AW(AW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wd_ready(wd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_id(rsp_id), .rsp_last(rsp_last), .rsp_err(rsp_err),
  .mem_we(mem_we), .mem_addr(ptr),
  .rmw_rd_phase(st == spad_pkg::S_MR), .rmw_wr_phase(st == spad_pkg::S_MW),
  .err_q(err_q)
);

// File: tb/sim_spad_atomic.sv
`timescale 1ns/1ps
module sim_spad_atomic;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [9:0]  cmd_base = '0, cmd_ofs = '0;
  logic [2:0]  cmd_len = '0;
  logic [31:0] cmd_mask = '0;
  logic [3:0]  cmd_id = '0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [31:0] wd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [3:0]  rsp_id;
  logic        rsp_last, rsp_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] r_data;
  logic [3:0]  r_id;
  logic        r_last, r_err;

  always #5 clk = ~clk;

  spad_atomic u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_ofs(cmd_ofs), .cmd_len(cmd_len),
    .cmd_mask(cmd_mask), .cmd_id(cmd_id), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_id(rsp_id), .rsp_last(rsp_last), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [9:0] a, input logic [9:0] b,
                          input logic [2:0] len, input logic [31:0] mask, input logic [3:0] id);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = a; cmd_ofs = b;
    cmd_len = len; cmd_mask = mask; cmd_id = id;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_wd(input logic [31:0] d);
    wd_valid = 1'b1; wd_data = d;
    while (!wd_ready) @(negedge clk);
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic get_rsp();
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_data; r_id = rsp_id; r_last = rsp_last; r_err = rsp_err;
    @(negedge clk);
  endtask

  task automatic wr_burst(input logic [9:0] a, input logic [9:0] b, input int n,
                          input logic [31:0] seed, input logic [3:0] id);
    send_cmd(3'd1, a, b, 3'(n-1), '0, id);
    for (int i = 0; i < n; i++) send_wd(seed + 32'(i));
    get_rsp();
    chk(r_last && !r_err && r_id == id, "R9 write done beat", {r_id, 26'd0, r_err, r_last}, {id, 28'd1});
  endtask

  task automatic rd_one(input logic [9:0] a, input logic [9:0] b, input logic [31:0] exp, input string req);
    send_cmd(3'd0, a, b, 3'd0, '0, 4'h3);
    get_rsp();
    chk(r_data == exp && r_last && !r_err, req, r_data, exp);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R9 reset cmd_ready", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_burst();
    wr_burst(10'd100, 10'd23, 4, 32'hA000_0010, 4'h5);
    send_cmd(3'd0, 10'd120, 10'd3, 3'd3, '0, 4'h9);
    for (int i = 0; i < 4; i++) begin
      get_rsp();
      chk(r_data == 32'hA000_0010 + 32'(i), "R1 R3 read burst data", r_data, 32'hA000_0010 + 32'(i));
      chk(r_last == (i == 3), "R3 last flag position", 32'(r_last), 32'(i == 3));
      chk(r_id == 4'h9, "R9 id echo", 32'(r_id), 32'h9);
    end
  endtask

  task automatic t_wrap();
    wr_burst(10'd1000, 10'd22, 3, 32'h5500_0000, 4'h1);
    rd_one(10'd0, 10'd0, 32'h5500_0002, "R4 wrapped word at 0");
    rd_one(10'd1023, 10'd0, 32'h5500_0001, "R4 word 1023");
    rd_one(10'd1, 10'd1021, 32'h5500_0000, "R1 sum addressing at 1022");
  endtask

  task automatic t_range();
    wr_burst(10'd76, 10'd0, 1, 32'h1234_5678, 4'h2);
    send_cmd(3'd1, 10'd1000, 10'd100, 3'd1, '0, 4'h7);
    send_wd(32'hDEAD_0000); send_wd(32'hDEAD_0001);
    get_rsp();
    chk(r_err && r_last && r_id == 4'h7, "R2 write out of range flagged", {31'd0, r_err}, 32'd1);
    send_cmd(3'd2, 10'd1000, 10'd100, 3'd0, 32'hFFFF_FFFF, 4'h6);
    get_rsp();
    chk(r_err && r_data == 0, "R2 set out of range flagged", r_data, 32'd0);
    send_cmd(3'd0, 10'd1023, 10'd1, 3'd2, '0, 4'h4);
    get_rsp();
    chk(r_err && r_last, "R2 read out of range single beat", {r_err, r_last}, 2'b11);
    rd_one(10'd76, 10'd0, 32'h1234_5678, "R2 memory unchanged");
  endtask

  task automatic t_bits();
    wr_burst(10'd500, 10'd0, 1, 32'h0F0F_00FF, 4'h0);
    send_cmd(3'd2, 10'd250, 10'd250, 3'd0, 32'hF000_0100, 4'hA);
    get_rsp();
    chk(r_data == 0 && r_id == 4'hA, "R5 set returns zero", r_data, 32'd0);
    rd_one(10'd500, 10'd0, 32'hFF0F_01FF, "R5 set result");
    send_cmd(3'd3, 10'd500, 10'd0, 3'd0, 32'h0F00_000F, 4'hB);
    get_rsp();
    chk(r_data == 0, "R5 clear returns zero", r_data, 32'd0);
    rd_one(10'd500, 10'd0, 32'hF00F_01F0, "R5 clear result");
    send_cmd(3'd4, 10'd500, 10'd0, 3'd0, 32'h0000_0003, 4'hC);
    get_rsp();
    chk(r_data == 32'hF00F_01F0, "R6 test-and-set old value", r_data, 32'hF00F_01F0);
    rd_one(10'd500, 10'd0, 32'hF00F_01F3, "R6 R8 test-and-set update");
    send_cmd(3'd5, 10'd500, 10'd0, 3'd0, 32'hF000_0001, 4'hD);
    get_rsp();
    chk(r_data == 32'hF00F_01F3, "R6 test-and-clear old value", r_data, 32'hF00F_01F3);
    rd_one(10'd500, 10'd0, 32'h000F_01F2, "R6 test-and-clear update");
  endtask

  task automatic t_incr();
    wr_burst(10'd7, 10'd0, 1, 32'hFFFF_FFFE, 4'h0);
    send_cmd(3'd6, 10'd3, 10'd4, 3'd0, '0, 4'hE);
    chk(wd_ready == 1'b0, "R7 no write data taken", 32'(wd_ready), 32'd0);
    get_rsp();
    chk(r_data == 0 && r_last && r_id == 4'hE, "R7 incr response", r_data, 32'd0);
    rd_one(10'd7, 10'd0, 32'hFFFF_FFFF, "R7 incr once");
    send_cmd(3'd6, 10'd7, 10'd0, 3'd0, '0, 4'hE);
    get_rsp();
    rd_one(10'd7, 10'd0, 32'h0000_0000, "R7 incr wraps");
  endtask

  task automatic t_rsv();
    wr_burst(10'd9, 10'd0, 1, 32'h0000_AAAA, 4'h0);
    send_cmd(3'd7, 10'd9, 10'd0, 3'd0, 32'hFFFF_FFFF, 4'h8);
    get_rsp();
    chk(r_err && r_last && r_id == 4'h8, "R11 reserved flagged", {31'd0, r_err}, 32'd1);
    rd_one(10'd9, 10'd0, 32'h0000_AAAA, "R11 memory unchanged");
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    wr_burst(10'd300, 10'd0, 2, 32'hBEEF_0000, 4'h0);
    rsp_ready = 1'b0;
    send_cmd(3'd0, 10'd300, 10'd0, 3'd1, '0, 4'h2);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held && !cmd_ready, "R10 beat held under stall", rsp_data, held);
    end
    rsp_ready = 1'b1;
    chk(held == 32'hBEEF_0000, "R10 first beat value", held, 32'hBEEF_0000);
    @(negedge clk);
    get_rsp();
    chk(r_data == 32'hBEEF_0001 && r_last, "R10 second beat after release", r_data, 32'hBEEF_0001);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst();
    t_wrap();
    t_range();
    t_bits();
    t_incr();
    t_rsv();
    t_backpressure();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule